// File: doc/BRIEF.md
# Host Byte Port for a 16-bit Data Register

This block lets an 8-bit host bus talk to a 16-bit data word held inside a signal-processing core. The host sees two byte-wide locations chosen by one address line: the data location, which carries the 16-bit word one byte at a time, and the status location, which returns the upper half of a 16-bit status word. The core side can write or read the data word, load the control bits of the status word, and drive two general-purpose pins from it.

Hand-off between the two sides uses a ready flag. Any flagged core access to the data word raises the flag. The host access that finishes the word lowers it. A control bit selects the transfer width. In wide mode a word moves as two bytes, upper byte first, and a mid-word flag is up between the two bytes. In narrow mode only the lower byte moves. While the ready flag is low, the host is locked out of the data word.

Host strobes are active-low levels sampled on the block clock. Each clock cycle with chip select and exactly one of read or write low counts as one access. Read data for the host is driven combinationally during that cycle.

Top module: `hpdr_port`

## Requirements
- R1: After reset the data word is 0x0000, all status bits are 0 (wide mode, ready flag low, mid-word flag low), both pins are low, and the last delivered host byte is 0x00.
- R2: The status word packs bit 15 ready flag, bit 14 user flag 1, bit 13 user flag 0, bit 12 mid-word flag, bit 11 DMA enable, bit 10 width select (0 = wide, 1 = narrow), bit 9 serial-out width, bit 8 serial-in width, bit 7 interrupt enable, bit 1 pin P1, bit 0 pin P0, and zero in bits 6..2. A host read with address 1 returns bits 15..8.
- R3: A core write (`int_wr`) or flagged core read (`int_rd`) sets the ready flag in the next cycle. `int_rdata` always shows the data word, and looking at it without `int_rd` leaves the flag unchanged.
- R4: In wide mode with the ready flag high, the first host data read returns bits 15..8 and sets the mid-word flag. The second returns bits 7..0, clears the mid-word flag and clears the ready flag.
- R5: In wide mode with the ready flag high, the first host data write loads bits 15..8 and the second loads bits 7..0, with the same flag behaviour as R4.
- R6: In narrow mode one host data access completes the word. A read returns bits 7..0. A write loads bits 7..0 and leaves bits 15..8 unchanged. The ready flag clears, and the mid-word flag stays 0.
- R7: While the ready flag is low, a host data read returns the last byte the host was given and a host data write leaves the data word unchanged.
- R8: The byte sequencer returns to the upper byte, with the mid-word flag cleared, whenever the core writes the data word or the width select bit changes value.
- R9: Pins P0 and P1 follow status bits 0 and 1 from the cycle after a control load.
- R10: When a core access (`int_wr` or `int_rd`) and a host data access fall in the same cycle, the core access wins and the host access is ignored as in R7.
- R11: A host write to address 1, any strobe with chip select high, and a cycle with both strobes low change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address: 0 data, 1 status |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Host read byte |
| int_wr | input | 1 | Core write of the data word (sets ready) |
| int_rd | input | 1 | Flagged core read of the data word (sets ready) |
| int_wdata | input | 16 | Core write word |
| int_rdata | output | 16 | Current data word |
| int_ctl_we | input | 1 | Load control bits of the status word |
| int_ctl_wdata | input | 16 | Control bits, status layout; bits 15, 12 and 6..2 ignored |
| int_status | output | 16 | Full status word |
| pin_p0 | output | 1 | General-purpose pin from status bit 0 |
| pin_p1 | output | 1 | General-purpose pin from status bit 1 |

## Verification
The hardest situations to reach are those where the byte sequencer is in the middle of a word when something else happens: a core write arrives, the width select flips, or a core access collides with a host strobe in the same cycle. The stimulus leaves a wide transfer half done on purpose before each of these events, then reads on to show which byte comes next. A long pseudo-random stretch mixes every access type, including colliding ones, against the bench's own model of the word, the flags and the last delivered byte.

// File: rtl/hpdr_pkg.sv
package hpdr_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // status bit positions (host decodes the upper byte)
  localparam int SB_RQM  = 15;
  localparam int SB_UF1  = 14;
  localparam int SB_UF0  = 13;
  localparam int SB_MID  = 12;
  localparam int SB_DMA  = 11;
  localparam int SB_NARW = 10;
  localparam int SB_SOW  = 9;
  localparam int SB_SIW  = 8;
  localparam int SB_IEN  = 7;
  localparam int SB_P1   = 1;
  localparam int SB_P0   = 0;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic uf1;
    logic uf0;
    logic dma;
    logic narrow;
    logic so_w;
    logic si_w;
    logic ien;
    logic p1;
    logic p0;
  } ctl_t;

  function automatic byte_t pick_byte(word_t w, logic upper);
    return upper ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic word_t merge_byte(word_t w, byte_t b, logic upper);
    word_t r;
    r = w;
    if (upper) r[WORD_W-1:BYTE_W] = b;
    else       r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  function automatic ctl_t unpack_ctl(word_t w);
    ctl_t c;
    c.uf1    = w[SB_UF1];
    c.uf0    = w[SB_UF0];
    c.dma    = w[SB_DMA];
    c.narrow = w[SB_NARW];
    c.so_w   = w[SB_SOW];
    c.si_w   = w[SB_SIW];
    c.ien    = w[SB_IEN];
    c.p1     = w[SB_P1];
    c.p0     = w[SB_P0];
    return c;
  endfunction

  function automatic word_t pack_status(ctl_t c, logic rqm, logic mid);
    word_t s;
    s = '0;
    s[SB_RQM]  = rqm;
    s[SB_UF1]  = c.uf1;
    s[SB_UF0]  = c.uf0;
    s[SB_MID]  = mid;
    s[SB_DMA]  = c.dma;
    s[SB_NARW] = c.narrow;
    s[SB_SOW]  = c.so_w;
    s[SB_SIW]  = c.si_w;
    s[SB_IEN]  = c.ien;
    s[SB_P1]   = c.p1;
    s[SB_P0]   = c.p0;
    return s;
  endfunction

endpackage

// File: rtl/hpdr_host_decode.sv
module hpdr_host_decode (
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic a0,
  output logic data_rd,
  output logic data_wr,
  output logic stat_rd,
  output logic stat_wr
);

  logic rd_evt;
  logic wr_evt;

  // exactly one strobe with chip select counts as an access
  assign rd_evt = !cs_n && !rd_n &&  wr_n;
  assign wr_evt = !cs_n &&  rd_n && !wr_n;

  assign data_rd = rd_evt && !a0;
  assign data_wr = wr_evt && !a0;
  assign stat_rd = rd_evt &&  a0;
  assign stat_wr = wr_evt &&  a0;

endmodule

// File: rtl/hpdr_status_reg.sv
module hpdr_status_reg
  import hpdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_we,
  input  word_t ctl_wdata,
  output ctl_t  ctl,
  output logic  width_flip
);

  ctl_t ctl_q;
  ctl_t ctl_new;

  assign ctl_new    = unpack_ctl(ctl_wdata);
  assign width_flip = ctl_we && (ctl_new.narrow != ctl_q.narrow);
  assign ctl        = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_new;
  end

  AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q.p0 == $past(ctl_wdata[SB_P0])) && (ctl_q.p1 == $past(ctl_wdata[SB_P1]))); // R9

endmodule

// File: rtl/hpdr_dr_seq.sv
module hpdr_dr_seq
  import hpdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  int_wr,
  input  logic  int_rd,
  input  word_t int_wdata,
  input  logic  narrow,
  input  logic  width_flip,
  input  logic  host_data_rd,
  input  logic  host_data_wr,
  input  byte_t host_din,
  output word_t dr,
  output logic  rqm,
  output logic  mid,
  output byte_t data_byte
);

  word_t dr_q;
  logic  rqm_q;
  logic  mid_q;
  byte_t last_q;

  logic  int_busy;
  logic  host_ok;
  logic  acc_rd;
  logic  acc_wr;
  logic  host_acc;
  logic  cur_upper;
  logic  word_done;
  byte_t cur_byte;

  assign int_busy  = int_wr || int_rd;
  assign host_ok   = rqm_q && !int_busy;
  assign acc_rd    = host_data_rd && host_ok;
  assign acc_wr    = host_data_wr && host_ok;
  assign host_acc  = acc_rd || acc_wr;
  assign cur_upper = !narrow && !mid_q;
  assign word_done = host_acc && (narrow || mid_q);
  assign cur_byte  = pick_byte(dr_q, cur_upper);
  assign data_byte = acc_rd ? cur_byte : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= '0;
      rqm_q  <= 1'b0;
      mid_q  <= 1'b0;
      last_q <= '0;
    end else begin
      if (int_wr) begin
        dr_q  <= int_wdata;
        rqm_q <= 1'b1;
        mid_q <= 1'b0;
      end else if (int_rd) begin
        rqm_q <= 1'b1;
      end else if (host_acc) begin
        if (acc_wr) dr_q   <= merge_byte(dr_q, host_din, cur_upper);
        if (acc_rd) last_q <= cur_byte;
        if (word_done) begin
          rqm_q <= 1'b0;
          mid_q <= 1'b0;
        end else begin
          mid_q <= 1'b1;
        end
      end
      if (width_flip) mid_q <= 1'b0;
    end
  end

  assign dr  = dr_q;
  assign rqm = rqm_q;
  assign mid = mid_q;

  AST_RQM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr || int_rd) |=> rqm_q); // R3

  AST_RQM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !rqm_q); // R4

  AST_NARROW_NO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> !mid_q); // R6

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_wr && !rqm_q && !int_wr) |=> $stable(dr_q)); // R7

  AST_CORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rd && !int_wr && host_data_wr) |=> $stable(dr_q)); // R10

endmodule

// File: rtl/hpdr_port.sv
module hpdr_port
  import hpdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_a0,
  input  logic [BYTE_W-1:0] host_din,
  output logic [BYTE_W-1:0] host_dout,
  input  logic              int_wr,
  input  logic              int_rd,
  input  logic [WORD_W-1:0] int_wdata,
  output logic [WORD_W-1:0] int_rdata,
  input  logic              int_ctl_we,
  input  logic [WORD_W-1:0] int_ctl_wdata,
  output logic [WORD_W-1:0] int_status,
  output logic              pin_p0,
  output logic              pin_p1
);

  logic  host_data_rd;
  logic  host_data_wr;
  logic  host_stat_rd;
  logic  host_stat_wr;
  ctl_t  ctl;
  logic  width_flip;
  word_t dr;
  logic  rqm;
  logic  mid;
  byte_t data_byte;
  word_t status;

  hpdr_host_decode u_dec (
    .cs_n    (host_cs_n),
    .rd_n    (host_rd_n),
    .wr_n    (host_wr_n),
    .a0      (host_a0),
    .data_rd (host_data_rd),
    .data_wr (host_data_wr),
    .stat_rd (host_stat_rd),
    .stat_wr (host_stat_wr)
  );

  hpdr_status_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (int_ctl_we),
    .ctl_wdata  (int_ctl_wdata),
    .ctl        (ctl),
    .width_flip (width_flip)
  );

  hpdr_dr_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .int_wr       (int_wr),
    .int_rd       (int_rd),
    .int_wdata    (int_wdata),
    .narrow       (ctl.narrow),
    .width_flip   (width_flip),
    .host_data_rd (host_data_rd),
    .host_data_wr (host_data_wr),
    .host_din     (host_din),
    .dr           (dr),
    .rqm          (rqm),
    .mid          (mid),
    .data_byte    (data_byte)
  );

  assign status     = pack_status(ctl, rqm, mid);
  assign int_status = status;
  assign int_rdata  = dr;
  assign pin_p0     = ctl.p0;
  assign pin_p1     = ctl.p1;
  assign host_dout  = host_stat_rd ? status[WORD_W-1:BYTE_W] : data_byte;

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat_wr && !int_ctl_we && !int_wr && !int_rd) |=> $stable(int_status)); // R11

endmodule

// File: tb/hpdr_port_tb.sv
module hpdr_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs_n = 1'b1;
  logic        host_rd_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic        host_a0 = 1'b0;
  logic [7:0]  host_din = '0;
  logic [7:0]  host_dout;
  logic        int_wr = 1'b0;
  logic        int_rd = 1'b0;
  logic [15:0] int_wdata = '0;
  logic [15:0] int_rdata;
  logic        int_ctl_we = 1'b0;
  logic [15:0] int_ctl_wdata = '0;
  logic [15:0] int_status;
  logic        pin_p0;
  logic        pin_p1;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] m_word = '0;
  logic [15:0] m_ctl = '0;
  bit          m_ready = 0;
  bit          m_mid = 0;
  logic [7:0]  m_last = '0;
  localparam logic [15:0] CTL_MASK = 16'h6F83;

  always #5 clk = ~clk;

  hpdr_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_a0(host_a0), .host_din(host_din), .host_dout(host_dout),
    .int_wr(int_wr), .int_rd(int_rd), .int_wdata(int_wdata), .int_rdata(int_rdata),
    .int_ctl_we(int_ctl_we), .int_ctl_wdata(int_ctl_wdata), .int_status(int_status),
    .pin_p0(pin_p0), .pin_p1(pin_p1)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = m_ctl;
    s[15] = m_ready;
    s[12] = m_mid;
    return s;
  endfunction

  task automatic idle();
    host_cs_n = 1; host_rd_n = 1; host_wr_n = 1; host_a0 = 0; host_din = '0;
    int_wr = 0; int_rd = 0; int_wdata = '0; int_ctl_we = 0; int_ctl_wdata = '0;
  endtask

  // inputs are set just after a falling edge; run one clock and compare
  task automatic do_cycle(string tag);
    bit rd_act, wr_act, core, ok, upper, narrow;
    logic [7:0] sel, exp_out;
    logic [15:0] n_word;
    logic [15:0] n_ctl;
    bit n_ready, n_mid;
    logic [7:0] n_last;
    #1;
    rd_act = !host_cs_n && !host_rd_n && host_wr_n;
    wr_act = !host_cs_n && host_rd_n && !host_wr_n;
    core   = int_wr || int_rd;
    ok     = m_ready && !core;
    narrow = m_ctl[10];
    upper  = !narrow && !m_mid;
    sel    = upper ? m_word[15:8] : m_word[7:0];
    if (rd_act) begin
      if (host_a0) exp_out = exp_status() >> 8;
      else         exp_out = ok ? sel : m_last;
      check(tag, "host_dout", {8'h00, host_dout}, {8'h00, exp_out});
    end
    n_word = m_word; n_ctl = m_ctl; n_ready = m_ready; n_mid = m_mid; n_last = m_last;
    if (int_wr) begin
      n_word = int_wdata; n_ready = 1; n_mid = 0;
    end else if (int_rd) begin
      n_ready = 1;
    end else if (ok && !host_a0 && (rd_act || wr_act)) begin
      if (wr_act) begin
        if (upper) n_word[15:8] = host_din;
        else       n_word[7:0]  = host_din;
      end
      if (rd_act) n_last = sel;
      if (narrow || m_mid) begin n_ready = 0; n_mid = 0; end
      else n_mid = 1;
    end
    if (int_ctl_we) begin
      n_ctl = int_ctl_wdata & CTL_MASK;
      if (int_ctl_wdata[10] != m_ctl[10]) n_mid = 0;
    end
    @(posedge clk);
    m_word = n_word; m_ctl = n_ctl; m_ready = n_ready; m_mid = n_mid; m_last = n_last;
    @(negedge clk);
    check(tag, "int_status", int_status, exp_status());
    check(tag, "int_rdata", int_rdata, m_word);
    check(tag, "pins", {14'h0, pin_p1, pin_p0}, {14'h0, m_ctl[1], m_ctl[0]});
    idle();
  endtask

  task automatic host_read(bit a, string tag);
    idle(); host_cs_n = 0; host_rd_n = 0; host_a0 = a; do_cycle(tag);
  endtask

  task automatic host_write(bit a, logic [7:0] d, string tag);
    idle(); host_cs_n = 0; host_wr_n = 0; host_a0 = a; host_din = d; do_cycle(tag);
  endtask

  task automatic core_write(logic [15:0] w, string tag);
    idle(); int_wr = 1; int_wdata = w; do_cycle(tag);
  endtask

  task automatic core_read(string tag);
    idle(); int_rd = 1; do_cycle(tag);
  endtask

  task automatic ctl_load(logic [15:0] w, string tag);
    idle(); int_ctl_we = 1; int_ctl_wdata = w; do_cycle(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "status", int_status, 16'h0000);
    check("R1", "rdata", int_rdata, 16'h0000);
    check("R1", "pins", {14'h0, pin_p1, pin_p0}, 16'h0);
    // R7 locked data read returns last byte (0 after reset)
    host_read(0, "R7");
    host_write(0, 8'h77, "R7");

    // R2 status packing and host view; R9 pins
    ctl_load(16'hFFFF, "R2");
    host_read(1, "R2");
    ctl_load(16'h6B83, "R9");
    host_read(1, "R2");
    ctl_load(16'h0001, "R9");
    ctl_load(16'h0002, "R9");

    // R3 core write sets ready; R4 wide read order
    core_write(16'hA55A, "R3");
    host_read(1, "R2");
    host_read(0, "R4");
    host_read(1, "R4");
    host_read(0, "R4");
    host_read(0, "R7");

    // R3 flagged read; R5 wide write order
    core_read("R3");
    host_write(0, 8'h12, "R5");
    host_write(0, 8'h34, "R5");
    host_write(0, 8'h99, "R7");
    host_read(0, "R7");

    // R8 core write mid-word restarts at upper byte
    core_write(16'hBEEF, "R8");
    host_read(0, "R8");
    core_write(16'hC0DE, "R8");
    host_read(0, "R8");
    host_read(0, "R8");
    // R8 width flip mid-word; R6 narrow read
    core_read("R8");
    host_read(0, "R8");
    ctl_load(16'h0400, "R8");
    host_read(0, "R6");

    // R6 narrow mode read and write
    core_write(16'h1357, "R6");
    host_read(0, "R6");
    core_read("R6");
    host_write(0, 8'hAA, "R6");
    host_read(0, "R7");

    // R8 back to wide
    core_read("R8");
    ctl_load(16'h0000, "R8");
    host_read(0, "R8");
    host_read(0, "R8");

    // R10 collisions
    core_read("R10");
    idle(); int_wr = 1; int_wdata = 16'h2222; host_cs_n = 0; host_rd_n = 0; do_cycle("R10");
    idle(); int_rd = 1; host_cs_n = 0; host_wr_n = 0; host_din = 8'h5C; do_cycle("R10");
    host_read(0, "R10");
    host_read(0, "R10");

    // R11 ignored accesses
    core_read("R11");
    host_write(1, 8'hFF, "R11");
    idle(); host_rd_n = 0; do_cycle("R11");
    idle(); host_wr_n = 0; host_din = 8'h11; do_cycle("R11");
    idle(); host_cs_n = 0; host_rd_n = 0; host_wr_n = 0; host_din = 8'h11; do_cycle("R11");
    host_read(0, "R11");
    host_read(0, "R11");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 15);
      idle();
      case (sel)
        0: begin int_wr = 1; int_wdata = 16'($urandom); end
        1: int_rd = 1;
        2: begin int_ctl_we = 1; int_ctl_wdata = 16'($urandom); end
        3, 4, 5, 6: begin host_cs_n = 0; host_rd_n = 0; host_a0 = ($urandom_range(0, 5) == 0); end
        7, 8, 9: begin host_cs_n = 0; host_wr_n = 0; host_din = 8'($urandom); end
        10: begin host_cs_n = 0; host_rd_n = 0; int_wr = 1; int_wdata = 16'($urandom); end
        11: begin host_cs_n = 0; host_wr_n = 0; int_rd = 1; host_din = 8'($urandom); end
        12: begin host_cs_n = 0; host_wr_n = 0; host_a0 = 1; host_din = 8'($urandom); end
        default: ;
      endcase
      do_cycle("MIX R4 R5 R6 R7 R8 R10");
    end

    summary();
  end

endmodule